// File: doc/BRIEF.md
# SPI Master Interrupt Register Block

This block gathers the interrupt sources of an SPI master whose transmit and receive paths each use a byte FIFO of `FIFO_DEPTH` entries (32 by default). It builds a 7-bit status word from two kinds of bits. Three sticky event bits latch one-cycle pulses for transmit underflow, receive overflow and mode fail. Four level bits are derived every cycle from the FIFO fill counts, the full flags and two programmable thresholds. A mask gates the status word, and the single active-high `irq` output is raised whenever any unmasked status bit is set.

Software reaches the block through a simple word-addressed port. A write is accepted on any cycle in which `reg_wr` is high. Read data is combinational from `reg_addr`. The register layout by word index is:

- 0: status. Reads the word. Writing 1 to a sticky bit clears it.
- 1: mask-set. Writing ORs the written bits into the mask.
- 2: mask-clear. Writing removes the written bits from the mask.
- 3: mask. Read only.
- 4: TX threshold.
- 5: RX threshold.

The thresholds let software choose how full the receive FIFO must get, or how empty the transmit FIFO must get, before the level interrupt fires. The FIFOs themselves and the serial shifter live outside this block.

Top module: `spi_irq_regs`

## Requirements
- R1: After reset, the mask is 0, all sticky bits are 0, both thresholds read 1 and `irq` is low.
- R2: A pulse on `ev_tx_underflow`, `ev_mode_fail` or `ev_rx_overflow` sets status bit 6, 1 or 0 respectively on the next clock edge. The bit stays set while no clear arrives.
- R3: Writing the status register (index 0) with a 1 in bit 6, 1 or 0 clears that sticky bit. A 0 in those positions leaves the bit unchanged. Written values in bits 5, 4, 3 and 2 have no effect.
- R4: When an event pulse and a write-one-to-clear of the same sticky bit occur in the same cycle, the bit ends up set.
- R5: Status bit 5 equals `rx_full` and status bit 3 equals `tx_full` in the same cycle.
- R6: Status bit 4 is 1 exactly when `rx_count` is greater than or equal to the RX threshold. Status bit 2 is 1 exactly when `tx_count` is less than the TX threshold. Both are evaluated combinationally in the current cycle.
- R7: A write to index 1 ORs `reg_wdata[6:0]` into the mask. A write to index 2 clears the mask bits where `reg_wdata[6:0]` is 1. A write to index 3 leaves the mask unchanged.
- R8: `irq` is high in the same cycle exactly when the bitwise AND of the mask and the status word is nonzero.
- R9: Indices 1, 2, 6 and 7 read 0. Reads of indices 0 and 3 return the 7-bit field with all upper bits 0.
- R10: Indices 4 and 5 store the low `CNT_W` bits of the written data and read them back zero-extended. Upper written bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Word index of the accessed register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| tx_count | input | CNT_W | Transmit FIFO fill count |
| rx_count | input | CNT_W | Receive FIFO fill count |
| tx_full | input | 1 | Transmit FIFO full flag |
| rx_full | input | 1 | Receive FIFO full flag |
| ev_tx_underflow | input | 1 | One-cycle transmit underflow event |
| ev_rx_overflow | input | 1 | One-cycle receive overflow event |
| ev_mode_fail | input | 1 | One-cycle mode-fail event |
| irq | output | 1 | Active-high interrupt request |

## Verification
The bench builds the block with `FIFO_DEPTH` 32, which gives `CNT_W` 6. Fill counts therefore span 0 to 32, while thresholds can be written anywhere from 0 to 63. This brings the edge settings within reach: a threshold of 0 keeps the RX level bit always set, and a threshold above the depth keeps the TX level bit always set. Directed cases place each threshold one below and exactly at a fill count. Random traffic then mixes event pulses with status clears, mask writes and threshold writes in the same cycles.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    // Width of the status, mask, set and clear fields
    localparam int unsigned IRQ_W = 7;

    // Status bit positions (software decodes these)
    localparam int unsigned BIT_TX_UF   = 6;
    localparam int unsigned BIT_RX_FULL = 5;
    localparam int unsigned BIT_RX_NE   = 4;
    localparam int unsigned BIT_TX_FULL = 3;
    localparam int unsigned BIT_TX_NF   = 2;
    localparam int unsigned BIT_MODE_F  = 1;
    localparam int unsigned BIT_RX_OVF  = 0;

    // Number of sticky event sources: {underflow, mode fail, overflow}
    localparam int unsigned N_STICKY = 3;

    // Word index of each register
    typedef enum logic [2:0] {
        SEL_STATUS   = 3'd0,
        SEL_MASK_SET = 3'd1,
        SEL_MASK_CLR = 3'd2,
        SEL_MASK     = 3'd3,
        SEL_TX_THR   = 3'd4,
        SEL_RX_THR   = 3'd5
    } reg_sel_e;

endpackage

// File: rtl/spi_irq_sticky.sv
// Sticky event latches: an event sets the bit, a clear request drops it,
// and an event in the same cycle as a clear keeps the bit set.
module spi_irq_sticky #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[i] <= 1'b0;
            end else if (ev[i]) begin
                q[i] <= 1'b1;
            end else if (clr[i]) begin
                q[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/spi_irq_level.sv
// Threshold comparators that produce the two level bits.
module spi_irq_level #(
    parameter int unsigned CNT_W = 6
) (
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_thr,
    input  logic [CNT_W-1:0] rx_thr,
    output logic             rx_at_thr,
    output logic             tx_below_thr
);

    always_comb begin
        rx_at_thr    = (rx_count >= rx_thr);
        tx_below_thr = (tx_count <  tx_thr);
    end

endmodule

// File: rtl/spi_irq_mask.sv
// Mask register that software updates only through set and clear strobes.
module spi_irq_mask #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] bits,
    output logic [W-1:0] mask_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (set_en) begin
            mask_q <= mask_q | bits;
        end else if (clr_en) begin
            mask_q <= mask_q & ~bits;
        end
    end

endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
    import spi_irq_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 32,
    parameter int unsigned DATA_W     = 32,
    // Derived: a fill count runs from 0 to FIFO_DEPTH
    parameter int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic              tx_full,
    input  logic              rx_full,
    input  logic              ev_tx_underflow,
    input  logic              ev_rx_overflow,
    input  logic              ev_mode_fail,
    output logic              irq
);

    localparam logic [CNT_W-1:0] THR_RST = CNT_W'(1);

    logic                wr_status, wr_set, wr_clr, wr_txthr, wr_rxthr;
    logic [CNT_W-1:0]    tx_thr_q, rx_thr_q;
    logic [N_STICKY-1:0] stk_ev, stk_clr, stk_q;
    logic                rx_at_thr, tx_below_thr;
    logic [IRQ_W-1:0]    mask_q, status_w;
    logic                unused_wdata;

    // Write decode
    always_comb begin
        wr_status = reg_wr && (reg_addr == SEL_STATUS);
        wr_set    = reg_wr && (reg_addr == SEL_MASK_SET);
        wr_clr    = reg_wr && (reg_addr == SEL_MASK_CLR);
        wr_txthr  = reg_wr && (reg_addr == SEL_TX_THR);
        wr_rxthr  = reg_wr && (reg_addr == SEL_RX_THR);
    end

    // Threshold registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_thr_q <= THR_RST;
            rx_thr_q <= THR_RST;
        end else begin
            if (wr_txthr) tx_thr_q <= reg_wdata[CNT_W-1:0];
            if (wr_rxthr) rx_thr_q <= reg_wdata[CNT_W-1:0];
        end
    end

    // Sticky sources, ordered {underflow, mode fail, overflow}
    always_comb begin
        stk_ev  = {ev_tx_underflow, ev_mode_fail, ev_rx_overflow};
        stk_clr = wr_status ? {reg_wdata[BIT_TX_UF], reg_wdata[BIT_MODE_F],
                               reg_wdata[BIT_RX_OVF]} : '0;
    end

    spi_irq_sticky #(.N(N_STICKY)) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (stk_ev),
        .clr   (stk_clr),
        .q     (stk_q)
    );

    spi_irq_level #(.CNT_W(CNT_W)) u_level (
        .tx_count     (tx_count),
        .rx_count     (rx_count),
        .tx_thr       (tx_thr_q),
        .rx_thr       (rx_thr_q),
        .rx_at_thr    (rx_at_thr),
        .tx_below_thr (tx_below_thr)
    );

    spi_irq_mask #(.W(IRQ_W)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (wr_set),
        .clr_en (wr_clr),
        .bits   (reg_wdata[IRQ_W-1:0]),
        .mask_q (mask_q)
    );

    // Status word assembly
    always_comb begin
        status_w              = '0;
        status_w[BIT_TX_UF]   = stk_q[2];
        status_w[BIT_RX_FULL] = rx_full;
        status_w[BIT_RX_NE]   = rx_at_thr;
        status_w[BIT_TX_FULL] = tx_full;
        status_w[BIT_TX_NF]   = tx_below_thr;
        status_w[BIT_MODE_F]  = stk_q[1];
        status_w[BIT_RX_OVF]  = stk_q[0];
    end

    always_comb irq = |(mask_q & status_w);

    // Read mux
    always_comb begin
        case (reg_addr)
            SEL_STATUS: reg_rdata = DATA_W'(status_w);
            SEL_MASK:   reg_rdata = DATA_W'(mask_q);
            SEL_TX_THR: reg_rdata = DATA_W'(tx_thr_q);
            SEL_RX_THR: reg_rdata = DATA_W'(rx_thr_q);
            default:    reg_rdata = '0;
        endcase
    end

    always_comb unused_wdata = ^reg_wdata;

endmodule

// File: rtl/spi_irq_regs_chk.sv
module spi_irq_regs_chk
    import spi_irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [2:0]       reg_addr,
    input logic [IRQ_W-1:0] wbits,
    input logic             ev_tx_underflow,
    input logic             ev_rx_overflow,
    input logic             ev_mode_fail,
    input logic             tx_full,
    input logic             rx_full,
    input logic [IRQ_W-1:0] status,
    input logic [IRQ_W-1:0] mask,
    input logic             irq
);

    p_uf_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_underflow |=> status[BIT_TX_UF]);

    p_ovf_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_overflow |=> status[BIT_RX_OVF]);

    p_w1c_uf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == SEL_STATUS && wbits[BIT_TX_UF] && !ev_tx_underflow)
        |=> !status[BIT_TX_UF]);

    p_event_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == SEL_STATUS && wbits[BIT_MODE_F] && ev_mode_fail)
        |=> status[BIT_MODE_F]);

    p_full_rx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> status[BIT_RX_FULL]);

    p_full_tx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |-> status[BIT_TX_FULL]);

    p_mask_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == SEL_MASK_SET)
        |=> ((mask & $past(wbits)) == $past(wbits)));

    p_mask_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == SEL_MASK_CLR)
        |=> ((mask & $past(wbits)) == '0));

    p_mask_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == SEL_MASK) |=> $stable(mask));

    p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);

endmodule

bind spi_irq_regs spi_irq_regs_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .reg_wr          (reg_wr),
    .reg_addr        (reg_addr),
    .wbits           (reg_wdata[6:0]),
    .ev_tx_underflow (ev_tx_underflow),
    .ev_rx_overflow  (ev_rx_overflow),
    .ev_mode_fail    (ev_mode_fail),
    .tx_full         (tx_full),
    .rx_full         (rx_full),
    .status          (status_w),
    .mask            (mask_q),
    .irq             (irq)
);

// File: tb/spi_irq_regs_tb.sv
module spi_irq_regs_tb;

    localparam int unsigned DEPTH = 32;
    localparam int unsigned DW    = 32;
    localparam int unsigned CW    = 6;

    logic          clk;
    logic          rst_n;
    logic          reg_wr;
    logic [2:0]    reg_addr;
    logic [DW-1:0] reg_wdata;
    logic [DW-1:0] reg_rdata;
    logic [CW-1:0] tx_count, rx_count;
    logic          tx_full, rx_full;
    logic          ev_tx_underflow, ev_rx_overflow, ev_mode_fail;
    logic          irq;

    spi_irq_regs #(.FIFO_DEPTH(DEPTH), .DATA_W(DW)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .reg_wr          (reg_wr),
        .reg_addr        (reg_addr),
        .reg_wdata       (reg_wdata),
        .reg_rdata       (reg_rdata),
        .tx_count        (tx_count),
        .rx_count        (rx_count),
        .tx_full         (tx_full),
        .rx_full         (rx_full),
        .ev_tx_underflow (ev_tx_underflow),
        .ev_rx_overflow  (ev_rx_overflow),
        .ev_mode_fail    (ev_mode_fail),
        .irq             (irq)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    // Reference state: sticky {underflow, mode fail, overflow}
    logic [2:0]    m_stk;
    logic [6:0]    m_mask;
    logic [CW-1:0] m_txthr, m_rxthr;

    function automatic logic [6:0] exp_status();
        return {m_stk[2], rx_full, (rx_count >= m_rxthr), tx_full,
                (tx_count < m_txthr), m_stk[1], m_stk[0]};
    endfunction

    function automatic logic exp_irq();
        return |(m_mask & exp_status());
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic [2:0] a, input logic [DW-1:0] d,
                        input logic [2:0] ev);
        @(negedge clk);
        reg_wr    = wr;
        reg_addr  = a;
        reg_wdata = d;
        {ev_tx_underflow, ev_mode_fail, ev_rx_overflow} = ev;
        @(posedge clk);
        if (wr) begin
            case (a)
                3'd0: m_stk  = m_stk & ~{d[6], d[1], d[0]};
                3'd1: m_mask = m_mask | d[6:0];
                3'd2: m_mask = m_mask & ~d[6:0];
                3'd4: m_txthr = d[CW-1:0];
                3'd5: m_rxthr = d[CW-1:0];
                default: ;
            endcase
        end
        m_stk = m_stk | ev;
        #1;
        reg_wr = 1'b0;
        {ev_tx_underflow, ev_mode_fail, ev_rx_overflow} = 3'b000;
    endtask

    task automatic set_fifo(input int tc, input int rc, input logic tf, input logic rf);
        @(negedge clk);
        tx_count = CW'(tc);
        rx_count = CW'(rc);
        tx_full  = tf;
        rx_full  = rf;
    endtask

    task automatic rd(input logic [2:0] a, input logic [DW-1:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #2;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic rd_status(input string tag);
        rd(3'd0, DW'(exp_status()), tag);
    endtask

    task automatic chk_irq(input string tag);
        @(negedge clk);
        #2;
        chk(tag, DW'(irq), DW'(exp_irq()));
    endtask

    initial begin
        #2_000_000;
        $display("FAIL watchdog expired actual=running expected=finished");
        n_chk++;
        n_fail++;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        tx_count = '0; rx_count = '0; tx_full = 1'b0; rx_full = 1'b0;
        ev_tx_underflow = 1'b0; ev_rx_overflow = 1'b0; ev_mode_fail = 1'b0;
        m_stk = '0; m_mask = '0; m_txthr = CW'(1); m_rxthr = CW'(1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(3'd0, 32'h0000_0004, "R1 status after reset");
        rd(3'd3, 32'h0, "R1 mask after reset");
        rd(3'd4, 32'h1, "R1 tx threshold after reset");
        rd(3'd5, 32'h1, "R1 rx threshold after reset");
        chk_irq("R1 irq after reset");

        // R2: sticky set and hold
        step(1'b0, 3'd0, 32'h0, 3'b100);
        rd_status("R2 underflow set");
        step(1'b0, 3'd0, 32'h0, 3'b011);
        step(1'b0, 3'd0, 32'h0, 3'b000);
        rd(3'd0, 32'h0000_0047, "R2 all sticky held");

        // R3: write-one-to-clear, level bits untouched
        step(1'b1, 3'd0, 32'h0000_0000, 3'b000);
        rd(3'd0, 32'h0000_0047, "R3 zero write keeps sticky");
        step(1'b1, 3'd0, 32'h0000_0040, 3'b000);
        rd(3'd0, 32'h0000_0007, "R3 clear underflow only");
        step(1'b1, 3'd0, 32'hFFFF_FFFF, 3'b000);
        rd(3'd0, 32'h0000_0004, "R3 clear all, level bit stays");

        // R4: event beats clear in the same cycle
        step(1'b1, 3'd0, 32'h0000_0002, 3'b010);
        rd(3'd0, 32'h0000_0006, "R4 mode fail event wins");
        step(1'b1, 3'd0, 32'h0000_0002, 3'b000);

        // R5: full flags
        set_fifo(32, 32, 1'b1, 1'b1);
        rd_status("R5 both full");
        set_fifo(0, 0, 1'b0, 1'b1);
        rd_status("R5 rx full only");

        // R6 / R10: threshold edges
        step(1'b1, 3'd5, 32'hFFFF_FFC5, 3'b000);
        rd(3'd5, 32'h5, "R10 rx threshold low bits only");
        step(1'b1, 3'd4, 32'h0000_0005, 3'b000);
        rd(3'd4, 32'h5, "R10 tx threshold readback");
        set_fifo(4, 4, 1'b0, 1'b0);
        rd(3'd0, 32'h0000_0004, "R6 count one below thresholds");
        set_fifo(5, 5, 1'b0, 1'b0);
        rd(3'd0, 32'h0000_0010, "R6 count equal to thresholds");
        step(1'b1, 3'd5, 32'h0, 3'b000);
        set_fifo(0, 0, 1'b0, 1'b0);
        rd(3'd0, 32'h0000_0014, "R6 rx threshold zero always set");
        step(1'b1, 3'd4, 32'h0000_003F, 3'b000);
        set_fifo(32, 0, 1'b0, 1'b0);
        rd(3'd0, 32'h0000_0014, "R6 tx threshold above depth");

        // R7: mask set / clear / read-only
        step(1'b1, 3'd1, 32'hFFFF_FF14, 3'b000);
        rd(3'd3, 32'h14, "R7 set bits");
        chk_irq("R8 irq with level bits unmasked");
        step(1'b1, 3'd1, 32'h01, 3'b000);
        rd(3'd3, 32'h15, "R7 set is OR");
        step(1'b1, 3'd2, 32'h04, 3'b000);
        rd(3'd3, 32'h11, "R7 clear bit");
        step(1'b1, 3'd3, 32'h7F, 3'b000);
        rd(3'd3, 32'h11, "R7 mask write ignored");

        // R8: irq follows unmasked status
        step(1'b1, 3'd5, 32'h1, 3'b000);
        chk_irq("R8 no unmasked bit");
        step(1'b0, 3'd0, 32'h0, 3'b001);
        chk_irq("R8 overflow unmasked raises irq");

        // R9: write-only and unmapped reads
        rd(3'd1, 32'h0, "R9 set register reads zero");
        rd(3'd2, 32'h0, "R9 clear register reads zero");
        rd(3'd6, 32'h0, "R9 unmapped index 6");
        rd(3'd7, 32'h0, "R9 unmapped index 7");

        // Random traffic, R2..R10
        for (int it = 0; it < 400; it++) begin
            logic [2:0] ev;
            logic       wr;
            logic [2:0] a;
            logic [DW-1:0] d;
            set_fifo($urandom_range(32, 0), $urandom_range(32, 0),
                     1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
            ev[0] = ($urandom_range(7, 0) == 0);
            ev[1] = ($urandom_range(7, 0) == 0);
            ev[2] = ($urandom_range(7, 0) == 0);
            wr = 1'($urandom_range(1, 0));
            a  = 3'($urandom_range(7, 0));
            d  = $urandom();
            if (a == 3'd4 || a == 3'd5) d = DW'($urandom_range(40, 0));
            step(wr, a, d, ev);
            rd_status("R6 random status");
            rd(3'd3, DW'(m_mask), "R7 random mask");
            chk_irq("R8 random irq");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule